// File: doc/BRIEF.md
# Static Branch Direction Predictor

This block sits beside the instruction decoder and decides, for every change-of-flow instruction that decode hands it, whether to issue a direction prediction and a target address. The direction follows a fixed rule: branches that always transfer control are predicted taken. Conditional branches with a backward displacement are predicted taken, and those with a forward displacement are predicted not-taken. A hint bit carried in the opcode flips the default for conditional branches only. A prediction is issued only when the target is known and the condition has not yet been evaluated. A register-sourced target counts as known only while no older instruction may still write that register.

The decoder offers one branch per handshake on a valid/ready input. The verdict comes out one cycle later on a valid/ready output stage. The input is back-pressured when the output holds an unconsumed result, so `dec_ready` is high whenever the output is empty or is being drained in the same cycle. A stalled result stays unchanged until it is taken. If a conditional branch arrives with its condition already evaluated, no prediction is made, and the known outcome is reported on a separate resolved pair.

Top module: `static_br_predictor`

## Requirements
- R1: Branch kinds 2'b00 (relative, always) and 2'b10 (register, always) are predicted taken whenever a prediction is issued. The hint bit and the condition-resolved flag have no effect on them.
- R2: Kind 2'b01 (relative, conditional) with the hint clear is predicted taken when the displacement's top bit is 1 (backward). It is predicted not-taken when that bit is 0, and a zero displacement counts as forward.
- R3: For conditional kinds (bit 0 of the kind set), a set hint bit inverts the default direction.
- R4: Kind 2'b11 (register, conditional) has no displacement. With the hint clear it is predicted not-taken.
- R5: A conditional branch whose condition is already evaluated gives `res_pred_valid`=0 and `res_resolved_valid`=1, with `res_resolved_taken` equal to the supplied outcome. In all other cases both resolved outputs are 0.
- R6: A register kind (bit 1 of the kind set) whose target register is still pending gives `res_pred_valid`=0.
- R7: For relative kinds the predicted target is the branch address plus four times the sign-extended word displacement, wrapping modulo 2^AW.
- R8: For register kinds the predicted target is the supplied register value.
- R9: When `res_pred_valid` is 0, `res_pred_taken` and `res_pred_target` are 0.
- R10: A branch accepted at a clock edge appears at the output after that edge, with `res_valid` high in the following cycle.
- R11: `dec_ready` equals `!res_valid || res_ready`. While `res_valid` is high and `res_ready` is low, all result outputs hold their values.
- R12: After reset `res_valid` is 0 and `dec_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decoder offers a branch |
| dec_ready | output | 1 | Block accepts the offered branch |
| dec_pc | input | AW | Address of the branch instruction |
| dec_kind | input | 2 | Bit 0 conditional, bit 1 register-sourced target |
| dec_disp | input | DW | Signed word displacement |
| dec_flip | input | 1 | Opcode hint that inverts the conditional default |
| dec_cond_done | input | 1 | Condition already evaluated |
| dec_cond_taken | input | 1 | Evaluated outcome of the condition |
| dec_reg_tgt | input | AW | Target value read from the register |
| dec_reg_busy | input | 1 | An older instruction may still write the target register |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Consumer takes the result |
| res_pred_valid | output | 1 | A prediction is issued |
| res_pred_taken | output | 1 | Predicted direction |
| res_pred_target | output | AW | Predicted target address |
| res_resolved_valid | output | 1 | Outcome was already known |
| res_resolved_taken | output | 1 | The known outcome |

## Verification
The clocked properties assume that every decode field is a defined 0 or 1 in any cycle where `dec_valid` and `dec_ready` are both high. They also assume that reset is applied before the first handshake. The stimulus drives every field with a defined value in every cycle, including idle ones, and holds reset low for several cycles at the start. Random back-pressure on `res_ready` exercises both the stall path and the accept-while-draining path against these assumptions.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
  typedef enum logic [1:0] {
    KIND_REL_ALWAYS = 2'b00,
    KIND_REL_COND   = 2'b01,
    KIND_REG_ALWAYS = 2'b10,
    KIND_REG_COND   = 2'b11
  } br_kind_e;

  function automatic logic kind_is_cond(input br_kind_e k);
    return k[0];
  endfunction

  function automatic logic kind_is_reg(input br_kind_e k);
    return k[1];
  endfunction
endpackage

// File: rtl/sbp_tgt_gen.sv
module sbp_tgt_gen
  import sbp_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 24
) (
  input  br_kind_e          kind,
  input  logic [AW-1:0]     pc,
  input  logic [DW-1:0]     disp,
  input  logic [AW-1:0]     reg_tgt,
  input  logic              reg_busy,
  output logic [AW-1:0]     tgt,
  output logic              known
);
  localparam int EXT = AW - DW - 2;

  logic [AW-1:0] byte_off;

  generate
    if (EXT > 0) begin : g_ext
      assign byte_off = {{EXT{disp[DW-1]}}, disp, 2'b00};
    end else begin : g_trunc
      assign byte_off = AW'({disp, 2'b00});
    end
  endgenerate

  always_comb begin
    if (kind_is_reg(kind)) begin
      tgt   = reg_tgt;
      known = !reg_busy;
    end else begin
      tgt   = pc + byte_off;
      known = 1'b1;
    end
  end

  // R6
  always_comb begin
    relative_known_chk: assert (kind_is_reg(kind) || known);
  end
endmodule

// File: rtl/sbp_dir_rule.sv
module sbp_dir_rule
  import sbp_pkg::*;
(
  input  br_kind_e kind,
  input  logic     disp_neg,
  input  logic     flip,
  input  logic     cond_done,
  input  logic     cond_taken,
  input  logic     tgt_known,
  output logic     issue,
  output logic     dir,
  output logic     res_known,
  output logic     res_dir
);
  logic default_dir;
  logic raw_dir;

  always_comb begin
    unique case (kind)
      KIND_REL_ALWAYS, KIND_REG_ALWAYS: default_dir = 1'b1;
      KIND_REL_COND:                    default_dir = disp_neg;
      KIND_REG_COND:                    default_dir = 1'b0;
      default:                          default_dir = 1'b0;
    endcase
    raw_dir   = kind_is_cond(kind) ? (default_dir ^ flip) : default_dir;
    issue     = tgt_known && (!kind_is_cond(kind) || !cond_done);
    dir       = issue && raw_dir;
    res_known = kind_is_cond(kind) && cond_done;
    res_dir   = res_known && cond_taken;
  end

  // R5
  always_comb begin
    pred_or_resolved_chk: assert (!(issue && res_known));
  end
endmodule

// File: rtl/sbp_pipe_reg.sv
module sbp_pipe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign in_ready  = !full_q || out_ready;
  assign out_valid = full_q;
  assign out_data  = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (in_ready) begin
      full_q <= in_valid;
      if (in_valid) data_q <= in_data;
    end
  end

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_data == $past(in_data)));
endmodule

// File: rtl/static_br_predictor.sv
module static_br_predictor
  import sbp_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dec_valid,
  output logic          dec_ready,
  input  logic [AW-1:0] dec_pc,
  input  logic [1:0]    dec_kind,
  input  logic [DW-1:0] dec_disp,
  input  logic          dec_flip,
  input  logic          dec_cond_done,
  input  logic          dec_cond_taken,
  input  logic [AW-1:0] dec_reg_tgt,
  input  logic          dec_reg_busy,
  output logic          res_valid,
  input  logic          res_ready,
  output logic          res_pred_valid,
  output logic          res_pred_taken,
  output logic [AW-1:0] res_pred_target,
  output logic          res_resolved_valid,
  output logic          res_resolved_taken
);
  localparam int PW = AW + 4;

  br_kind_e      kind;
  logic [AW-1:0] tgt_raw;
  logic          tgt_known;
  logic          issue, dir, res_known, res_dir;
  logic [AW-1:0] tgt_out;
  logic [PW-1:0] pay_in, pay_out;

  assign kind = br_kind_e'(dec_kind);

  sbp_tgt_gen #(.AW(AW), .DW(DW)) tgt_i (
    .kind     (kind),
    .pc       (dec_pc),
    .disp     (dec_disp),
    .reg_tgt  (dec_reg_tgt),
    .reg_busy (dec_reg_busy),
    .tgt      (tgt_raw),
    .known    (tgt_known)
  );

  sbp_dir_rule dir_i (
    .kind       (kind),
    .disp_neg   (dec_disp[DW-1]),
    .flip       (dec_flip),
    .cond_done  (dec_cond_done),
    .cond_taken (dec_cond_taken),
    .tgt_known  (tgt_known),
    .issue      (issue),
    .dir        (dir),
    .res_known  (res_known),
    .res_dir    (res_dir)
  );

  assign tgt_out = issue ? tgt_raw : '0;
  assign pay_in  = {issue, dir, tgt_out, res_known, res_dir};

  sbp_pipe_reg #(.W(PW)) pipe_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (dec_valid),
    .in_ready  (dec_ready),
    .in_data   (pay_in),
    .out_valid (res_valid),
    .out_ready (res_ready),
    .out_data  (pay_out)
  );

  assign {res_pred_valid, res_pred_taken, res_pred_target,
          res_resolved_valid, res_resolved_taken} = pay_out;

  // R1
  always_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && !dec_kind[0] && !(dec_kind[1] && dec_reg_busy))
      |=> (res_valid && res_pred_valid && res_pred_taken));

  // R6
  busy_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_kind[1] && dec_reg_busy)
      |=> (res_valid && !res_pred_valid));

  // R5
  resolved_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_ready && dec_kind[0] && dec_cond_done)
      |=> (res_resolved_valid && !res_pred_valid
           && res_resolved_taken == $past(dec_cond_taken)));

  // R9
  quiet_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_pred_valid) |-> (!res_pred_taken && res_pred_target == '0));

  // R12
  reset_empty_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!res_valid && dec_ready));
endmodule

// File: tb/static_br_predictor_tb_top.sv
module static_br_predictor_tb_top;
  localparam int AW = 32;
  localparam int DW = 24;
  localparam int PW = AW + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dec_valid = 1'b0;
  logic          dec_ready;
  logic [AW-1:0] dec_pc = '0;
  logic [1:0]    dec_kind = '0;
  logic [DW-1:0] dec_disp = '0;
  logic          dec_flip = 1'b0;
  logic          dec_cond_done = 1'b0;
  logic          dec_cond_taken = 1'b0;
  logic [AW-1:0] dec_reg_tgt = '0;
  logic          dec_reg_busy = 1'b0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic          res_pred_valid, res_pred_taken;
  logic [AW-1:0] res_pred_target;
  logic          res_resolved_valid, res_resolved_taken;

  int compared = 0;
  int mismatched = 0;
  logic [PW-1:0] expq[$];
  logic [1:0]    kindq[$];
  logic [PW-1:0] held;
  bit hold_pending = 0;
  bit lat_pending = 0;

  always #10 clk = ~clk;

  static_br_predictor #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .dec_valid(dec_valid), .dec_ready(dec_ready),
    .dec_pc(dec_pc), .dec_kind(dec_kind), .dec_disp(dec_disp),
    .dec_flip(dec_flip), .dec_cond_done(dec_cond_done),
    .dec_cond_taken(dec_cond_taken), .dec_reg_tgt(dec_reg_tgt),
    .dec_reg_busy(dec_reg_busy),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_pred_valid(res_pred_valid), .res_pred_taken(res_pred_taken),
    .res_pred_target(res_pred_target),
    .res_resolved_valid(res_resolved_valid),
    .res_resolved_taken(res_resolved_taken)
  );

  function automatic logic [PW-1:0] model(
    input logic [AW-1:0] pc, input logic [1:0] kind, input logic [DW-1:0] disp,
    input logic flip, input logic cd, input logic ct,
    input logic [AW-1:0] rt, input logic busy);
    logic cond, regk, known, pv, pt, rv, rk, dflt;
    logic [AW-1:0] tg;
    longint sd;
    cond  = kind[0];
    regk  = kind[1];
    known = !regk || !busy;
    pv    = known && (!cond || !cd);
    if (!cond) pt = 1'b1;
    else begin
      dflt = regk ? 1'b0 : disp[DW-1];
      pt = dflt ^ flip;
    end
    pt = pt && pv;
    sd = longint'($signed(disp));
    if (!pv) tg = '0;
    else if (regk) tg = rt;
    else tg = pc + AW'(sd * 4);
    rv = cond && cd;
    rk = rv && ct;
    return {pv, pt, tg, rv, rk};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input logic [PW-1:0] e, input logic [1:0] k);
    logic [PW-1:0] g;
    string tt, tg;
    g = {res_pred_valid, res_pred_taken, res_pred_target,
         res_resolved_valid, res_resolved_taken};
    if (!e[PW-1]) tt = "R9";
    else if (!k[0]) tt = "R1";
    else if (k[1]) tt = "R4";
    else tt = "R2";
    if (k[0] && dec_flip_seen) tt = "R3";
    tg = !e[PW-1] ? "R9" : (k[1] ? "R8" : "R7");
    chk(g[PW-1] == e[PW-1], (k[1] ? "R6" : "R5"), "pred_valid",
        AW'(g[PW-1]), AW'(e[PW-1]));
    chk(g[PW-2] == e[PW-2], tt, "pred_taken", AW'(g[PW-2]), AW'(e[PW-2]));
    chk(g[AW+1:2] == e[AW+1:2], tg, "pred_target", g[AW+1:2], e[AW+1:2]);
    chk(g[1:0] == e[1:0], "R5", "resolved pair", AW'(g[1:0]), AW'(e[1:0]));
  endtask

  bit dec_flip_seen;
  bit flipq[$];

  task automatic step();
    logic [PW-1:0] g;
    #1;
    g = {res_pred_valid, res_pred_taken, res_pred_target,
         res_resolved_valid, res_resolved_taken};
    if (hold_pending)
      chk(res_valid && g == held, "R11", "stalled result held", g[AW+1:2], held[AW+1:2]);
    if (lat_pending)
      chk(res_valid == 1'b1, "R10", "res_valid after accept", AW'(res_valid), 1);
    hold_pending = 0;
    lat_pending = 0;
    chk(dec_ready == (!res_valid || res_ready), "R11", "dec_ready rule",
        AW'(dec_ready), AW'(!res_valid || res_ready));
    if (res_valid && res_ready) begin
      if (expq.size() == 0) chk(1'b0, "R10", "unexpected result", 1, 0);
      else begin
        dec_flip_seen = flipq.pop_front();
        compare(expq.pop_front(), kindq.pop_front());
      end
    end else if (res_valid) begin
      hold_pending = 1;
      held = g;
    end
    if (dec_valid && dec_ready) begin
      expq.push_back(model(dec_pc, dec_kind, dec_disp, dec_flip, dec_cond_done,
                           dec_cond_taken, dec_reg_tgt, dec_reg_busy));
      kindq.push_back(dec_kind);
      flipq.push_back(dec_flip);
      lat_pending = 1;
    end
    @(negedge clk);
  endtask

  task automatic send(input logic [AW-1:0] pc, input logic [1:0] kind,
                      input logic [DW-1:0] disp, input logic flip, input logic cd,
                      input logic ct, input logic [AW-1:0] rt, input logic busy,
                      input logic rdy);
    dec_valid = 1'b1; dec_pc = pc; dec_kind = kind; dec_disp = disp;
    dec_flip = flip; dec_cond_done = cd; dec_cond_taken = ct;
    dec_reg_tgt = rt; dec_reg_busy = busy; res_ready = rdy;
    step();
  endtask

  task automatic idle(input logic rdy);
    dec_valid = 1'b0; res_ready = rdy;
    step();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12
    chk(res_valid == 1'b0, "R12", "res_valid after reset", AW'(res_valid), 0);
    chk(dec_ready == 1'b1, "R12", "dec_ready after reset", AW'(dec_ready), 1);
    @(negedge clk);

    // R1: hint and resolved flag ignored on always kinds
    send(32'h1000, 2'b00, 24'hFFFFF0, 1'b1, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1);
    send(32'h2000, 2'b10, 24'h000010, 1'b1, 1'b0, 1'b0, 32'h00ABC0, 1'b0, 1'b1);
    // R2: zero displacement is forward, backward taken
    send(32'h3000, 2'b01, 24'h000000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1);
    send(32'h3000, 2'b01, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1);
    // R3: hint inverts
    send(32'h3000, 2'b01, 24'hFFFFFF, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1);
    send(32'h3000, 2'b01, 24'h000005, 1'b1, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1);
    // R4 and R8: register conditional
    send(32'h4000, 2'b11, 24'hFFFFFF, 1'b0, 1'b0, 1'b0, 32'h5550, 1'b0, 1'b1);
    send(32'h4000, 2'b11, 24'h000000, 1'b1, 1'b0, 1'b0, 32'h6660, 1'b0, 1'b1);
    // R6: pending register
    send(32'h5000, 2'b10, 24'h0, 1'b0, 1'b0, 1'b0, 32'h7770, 1'b1, 1'b1);
    // R5: resolved with pending register
    send(32'h5000, 2'b11, 24'h0, 1'b0, 1'b1, 1'b1, 32'h7770, 1'b1, 1'b1);
    send(32'h5000, 2'b01, 24'hFFFFF0, 1'b0, 1'b1, 1'b0, 32'h0, 1'b0, 1'b1);
    // R7: wrap around and most negative displacement
    send(32'hFFFF_FFFC, 2'b00, 24'h000001, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1);
    send(32'h0000_0010, 2'b00, 24'h800000, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b1);
    // R11: back-pressure
    send(32'h8000, 2'b01, 24'hFFFFFE, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    send(32'h9000, 2'b00, 24'h000003, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    send(32'h9000, 2'b00, 24'h000003, 1'b0, 1'b0, 1'b0, 32'h0, 1'b0, 1'b0);
    idle(1'b1);
    idle(1'b1);

    for (int i = 0; i < 4000; i++) begin
      dec_valid      = ($urandom % 10) < 7;
      res_ready      = ($urandom % 10) < 7;
      dec_pc         = $urandom;
      dec_kind       = 2'($urandom);
      dec_disp       = DW'($urandom);
      dec_flip       = 1'($urandom);
      dec_cond_done  = 1'($urandom);
      dec_cond_taken = 1'($urandom);
      dec_reg_tgt    = $urandom;
      dec_reg_busy   = 1'($urandom);
      step();
    end
    repeat (4) idle(1'b1);
    chk(expq.size() == 0, "R10", "all results delivered", AW'(expq.size()), 0);
    summary();
    $finish;
  end
endmodule